// File: doc/BRIEF.md
# Byte-Serial Command Sequencer

This block is the control front end of a line-rendering engine. A host feeds it one byte at a time over a ready/valid handshake. Each command byte carries a three-bit operation code and a five-bit register or object-cell index. Some operations need one more byte, which follows the command on the same port. The sequencer decodes the command and then takes one of these actions:

- writes a register;
- presents a register on the shared output bus;
- pulses the object unit to load or store a cell;
- starts the transform datapath with its operand byte;
- hands control to the rasterizer.

The sequencer then waits for the addressed unit to finish before it fetches again.

The controller is one finite-state machine with seven states. The state register is held one-hot and is brought out directly on a seven-bit debug port. During a draw the machine leaves the host port closed, so no command can be accepted until the rasterizer reports completion. Transform and raster arithmetic are not part of this block. It only issues start strobes and waits for the done inputs.

Top module: `seq_cmd_ctrl`

## Requirements
- R1: While reset is asserted and in the first cycle after it is released, `state_dbg` is 7'b0000001 and `in_ready` is 1. In that state `reg_we`, `obj_load`, `obj_store`, `xf_start`, `draw_start` and `out_valid` are all 0.
- R2: A command byte holds the operation in bits [7:5] and the index in bits [4:0]. The operation codes are 000 register write, 001 register read-out, 010 object load, 011 object store, 100 translate, 101 skew, 110 draw and 111 unused.
- R3: After a register-write command, the next accepted byte raises `reg_we` in its accept cycle, with `reg_addr` equal to the index and `reg_wdata` equal to that byte. The sequencer then returns to fetch.
- R4: After a read-out command, `out_valid` is 1 from the next cycle and `out_byte` equals `reg_rdata` for `reg_addr` equal to the index. Both hold while `out_ready` is 0, and `in_ready` is 0 during that time. `out_byte` is 0 whenever `out_valid` is 0.
- R5: After an object load or store command, the next cycle carries a single-cycle `obj_load` or `obj_store` pulse with `obj_idx` equal to the index.
- R6: After a translate or skew command, the next accepted byte raises `xf_start` in its accept cycle, with `xf_operand` equal to that byte. `xf_skew` is 1 for skew and 0 for translate. `in_ready` then stays 0 until `xf_done` is seen, and is 1 in the cycle after it.
- R7: A draw command raises `draw_start` in its accept cycle. From the next cycle until `draw_done` is seen, `in_ready` is 0, `state_dbg` is 7'b1000000, and bytes offered by the host cause no strobe.
- R8: A command with code 111 causes no strobe, and the sequencer stays in fetch with `in_ready` 1.
- R9: `state_dbg` is always one-hot. Bit 0 is fetch, bit 1 is register-data wait, bit 2 is read-out, bit 3 is object pulse, bit 4 is operand wait, bit 5 is transform wait and bit 6 is draw wait.
- R10: At most one of `reg_we`, `obj_load`, `obj_store`, `xf_start` and `draw_start` is 1 in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_byte | input | 8 | Command or data byte from host |
| in_valid | input | 1 | Host offers `in_byte` |
| in_ready | output | 1 | Sequencer accepts a byte this cycle |
| out_byte | output | 8 | Register contents for read-out |
| out_valid | output | 1 | `out_byte` is valid |
| out_ready | input | 1 | Host takes `out_byte` |
| reg_addr | output | 5 | Register index for write and read-out |
| reg_we | output | 1 | Register write strobe |
| reg_wdata | output | 8 | Register write data |
| reg_rdata | input | 8 | Register read data for `reg_addr` |
| obj_load | output | 1 | Load object cell into working set |
| obj_store | output | 1 | Store working set into object cell |
| obj_idx | output | 5 | Object cell index |
| xf_start | output | 1 | Start transform |
| xf_skew | output | 1 | Transform is skew (1) or translate (0) |
| xf_operand | output | 8 | Transform operand byte |
| xf_done | input | 1 | Transform finished |
| draw_start | output | 1 | Start rasterizer |
| draw_done | input | 1 | Rasterizer finished |
| state_dbg | output | 7 | One-hot controller state |

## Verification
A wrong next-state choice appears on `state_dbg` in the very next cycle, because the state register drives those pins without any decoding. It also shows on `in_ready` in that same cycle, since the handshake is a direct OR of three state bits. A lost or misrouted index or opcode does not show until the strobe it feeds: the write, output, object or transform strobe one byte later. There it appears as a wrong address, a wrong `xf_skew` value or a missing pulse. A stuck wait state shows as `in_ready` staying low after the done input, so the bench checks the handshake again in the cycle right after each completion.

// File: rtl/seq_pkg.sv
package seq_pkg;

  localparam int OPC_W = 3;
  localparam int NST   = 7;

  typedef enum logic [OPC_W-1:0] {
    OPC_WREG  = 3'd0,
    OPC_RDOUT = 3'd1,
    OPC_OLOAD = 3'd2,
    OPC_OSTOR = 3'd3,
    OPC_TRANS = 3'd4,
    OPC_SKEW  = 3'd5,
    OPC_DRAW  = 3'd6,
    OPC_NONE  = 3'd7
  } opc_e;

  localparam int ST_FETCH = 0;
  localparam int ST_WDATA = 1;
  localparam int ST_RDOUT = 2;
  localparam int ST_OBJ   = 3;
  localparam int ST_ARG   = 4;
  localparam int ST_XWAIT = 5;
  localparam int ST_DWAIT = 6;

  typedef logic [NST-1:0] st_t;

  function automatic st_t st_bit(input int idx);
    st_t s;
    s = '0;
    s[idx] = 1'b1;
    return s;
  endfunction

  // state entered once a command byte is accepted
  function automatic st_t after_fetch(input opc_e op);
    case (op)
      OPC_WREG:            return st_bit(ST_WDATA);
      OPC_RDOUT:           return st_bit(ST_RDOUT);
      OPC_OLOAD, OPC_OSTOR: return st_bit(ST_OBJ);
      OPC_TRANS, OPC_SKEW: return st_bit(ST_ARG);
      OPC_DRAW:            return st_bit(ST_DWAIT);
      default:             return st_bit(ST_FETCH);
    endcase
  endfunction

endpackage

// File: rtl/seq_opreg.sv
module seq_opreg
  import seq_pkg::*;
#(
  parameter int DATA_W = 8,
  localparam int IDX_W = DATA_W - OPC_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cap,
  input  logic [DATA_W-1:0] byte_i,
  output opc_e              op_q,
  output logic [IDX_W-1:0]  idx_q
);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      op_q  <= OPC_NONE;
      idx_q <= '0;
    end else if (cap) begin
      op_q  <= opc_e'(byte_i[DATA_W-1 -: OPC_W]);
      idx_q <= byte_i[IDX_W-1:0];
    end
  end

endmodule

// File: rtl/seq_fsm.sv
module seq_fsm
  import seq_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic fetch_acc,
  input  opc_e fetch_op,
  input  logic in_valid,
  input  logic out_ready,
  input  logic xf_done,
  input  logic draw_done,
  output st_t  st_q
);

  st_t st_d;

  always_comb begin
    st_d = st_q;
    unique case (1'b1)
      st_q[ST_FETCH]: if (fetch_acc) st_d = after_fetch(fetch_op);
      st_q[ST_WDATA]: if (in_valid)  st_d = st_bit(ST_FETCH);
      st_q[ST_RDOUT]: if (out_ready) st_d = st_bit(ST_FETCH);
      st_q[ST_OBJ]:                  st_d = st_bit(ST_FETCH);
      st_q[ST_ARG]:   if (in_valid)  st_d = st_bit(ST_XWAIT);
      st_q[ST_XWAIT]: if (xf_done)   st_d = st_bit(ST_FETCH);
      st_q[ST_DWAIT]: if (draw_done) st_d = st_bit(ST_FETCH);
      default:                       st_d = st_bit(ST_FETCH);
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) st_q <= st_bit(ST_FETCH);
    else        st_q <= st_d;
  end

endmodule

// File: rtl/seq_drive.sv
module seq_drive
  import seq_pkg::*;
#(
  parameter int DATA_W = 8,
  localparam int IDX_W = DATA_W - OPC_W
) (
  input  st_t               st,
  input  opc_e              op_q,
  input  logic [IDX_W-1:0]  idx_q,
  input  logic              fetch_acc,
  input  opc_e              fetch_op,
  input  logic              in_valid,
  input  logic [DATA_W-1:0] in_byte,
  input  logic [DATA_W-1:0] reg_rdata,
  output logic              in_ready,
  output logic [DATA_W-1:0] out_byte,
  output logic              out_valid,
  output logic [IDX_W-1:0]  reg_addr,
  output logic              reg_we,
  output logic [DATA_W-1:0] reg_wdata,
  output logic              obj_load,
  output logic              obj_store,
  output logic [IDX_W-1:0]  obj_idx,
  output logic              xf_start,
  output logic              xf_skew,
  output logic [DATA_W-1:0] xf_operand,
  output logic              draw_start
);

  always_comb begin
    in_ready   = st[ST_FETCH] | st[ST_WDATA] | st[ST_ARG];
    out_valid  = st[ST_RDOUT];
    out_byte   = st[ST_RDOUT] ? reg_rdata : '0;
    reg_addr   = idx_q;
    reg_we     = st[ST_WDATA] & in_valid;
    reg_wdata  = in_byte;
    obj_idx    = idx_q;
    obj_load   = st[ST_OBJ] & (op_q == OPC_OLOAD);
    obj_store  = st[ST_OBJ] & (op_q == OPC_OSTOR);
    xf_start   = st[ST_ARG] & in_valid;
    xf_skew    = (op_q == OPC_SKEW);
    xf_operand = in_byte;
    draw_start = fetch_acc & (fetch_op == OPC_DRAW);
  end

endmodule

// File: rtl/seq_cmd_ctrl.sv
module seq_cmd_ctrl
  import seq_pkg::*;
#(
  parameter int DATA_W = 8,
  localparam int IDX_W = DATA_W - OPC_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DATA_W-1:0] in_byte,
  input  logic              in_valid,
  output logic              in_ready,
  output logic [DATA_W-1:0] out_byte,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [IDX_W-1:0]  reg_addr,
  output logic              reg_we,
  output logic [DATA_W-1:0] reg_wdata,
  input  logic [DATA_W-1:0] reg_rdata,
  output logic              obj_load,
  output logic              obj_store,
  output logic [IDX_W-1:0]  obj_idx,
  output logic              xf_start,
  output logic              xf_skew,
  output logic [DATA_W-1:0] xf_operand,
  input  logic              xf_done,
  output logic              draw_start,
  input  logic              draw_done,
  output logic [NST-1:0]    state_dbg
);

  st_t              st;
  opc_e             op_q;
  logic [IDX_W-1:0] idx_q;
  logic             fetch_acc;
  opc_e             fetch_op;

  // named internal events, visible to the checker
  assign fetch_acc = st[ST_FETCH] & in_valid;
  assign fetch_op  = opc_e'(in_byte[DATA_W-1 -: OPC_W]);
  assign state_dbg = st;

  seq_opreg #(.DATA_W(DATA_W)) u_opreg (
    .clk    (clk),
    .rst_n  (rst_n),
    .cap    (fetch_acc),
    .byte_i (in_byte),
    .op_q   (op_q),
    .idx_q  (idx_q)
  );

  seq_fsm u_fsm (
    .clk       (clk),
    .rst_n     (rst_n),
    .fetch_acc (fetch_acc),
    .fetch_op  (fetch_op),
    .in_valid  (in_valid),
    .out_ready (out_ready),
    .xf_done   (xf_done),
    .draw_done (draw_done),
    .st_q      (st)
  );

  seq_drive #(.DATA_W(DATA_W)) u_drive (
    .st         (st),
    .op_q       (op_q),
    .idx_q      (idx_q),
    .fetch_acc  (fetch_acc),
    .fetch_op   (fetch_op),
    .in_valid   (in_valid),
    .in_byte    (in_byte),
    .reg_rdata  (reg_rdata),
    .in_ready   (in_ready),
    .out_byte   (out_byte),
    .out_valid  (out_valid),
    .reg_addr   (reg_addr),
    .reg_we     (reg_we),
    .reg_wdata  (reg_wdata),
    .obj_load   (obj_load),
    .obj_store  (obj_store),
    .obj_idx    (obj_idx),
    .xf_start   (xf_start),
    .xf_skew    (xf_skew),
    .xf_operand (xf_operand),
    .draw_start (draw_start)
  );

endmodule

// File: rtl/seq_cmd_ctrl_chk.sv
module seq_cmd_ctrl_chk #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid,
  input logic              in_ready,
  input logic [DATA_W-1:0] out_byte,
  input logic              out_valid,
  input logic              out_ready,
  input logic              reg_we,
  input logic              obj_load,
  input logic              obj_store,
  input logic              xf_start,
  input logic              draw_start,
  input logic              xf_done,
  input logic              draw_done,
  input logic              fetch_acc,
  input logic [6:0]        state_dbg
);

  a_r1_ready_after_reset: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(rst_n) |-> (in_ready && state_dbg == 7'b0000001));

  a_r9_state_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot(state_dbg));

  a_r10_one_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({reg_we, obj_load, obj_store, xf_start, draw_start}) <= 1);

  a_r5_obj_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    (obj_load || obj_store) |=> !(obj_load || obj_store));

  a_r4_out_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_byte) && !in_ready));

  a_r4_out_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> (out_byte == '0));

  a_r3_we_on_accept: assert property (@(posedge clk) disable iff (!rst_n)
    reg_we |-> (in_valid && in_ready));

  a_r7_draw_closed: assert property (@(posedge clk) disable iff (!rst_n)
    (state_dbg[6] && !draw_done) |=> (state_dbg[6] && !in_ready && !reg_we && !xf_start));

  a_r7_draw_on_fetch: assert property (@(posedge clk) disable iff (!rst_n)
    draw_start |-> fetch_acc);

  a_r6_xf_wait: assert property (@(posedge clk) disable iff (!rst_n)
    (state_dbg[5] && !xf_done) |=> !in_ready);

endmodule

bind seq_cmd_ctrl seq_cmd_ctrl_chk #(.DATA_W(DATA_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .in_valid   (in_valid),
  .in_ready   (in_ready),
  .out_byte   (out_byte),
  .out_valid  (out_valid),
  .out_ready  (out_ready),
  .reg_we     (reg_we),
  .obj_load   (obj_load),
  .obj_store  (obj_store),
  .xf_start   (xf_start),
  .draw_start (draw_start),
  .xf_done    (xf_done),
  .draw_done  (draw_done),
  .fetch_acc  (fetch_acc),
  .state_dbg  (state_dbg)
);

// File: tb/test_seq_cmd_ctrl.sv
module test_seq_cmd_ctrl;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] in_byte = '0;
  logic       in_valid = 1'b0;
  logic       in_ready;
  logic [7:0] out_byte;
  logic       out_valid;
  logic       out_ready = 1'b0;
  logic [4:0] reg_addr;
  logic       reg_we;
  logic [7:0] reg_wdata;
  logic [7:0] reg_rdata;
  logic       obj_load, obj_store;
  logic [4:0] obj_idx;
  logic       xf_start, xf_skew;
  logic [7:0] xf_operand;
  logic       xf_done = 1'b0;
  logic       draw_start;
  logic       draw_done = 1'b0;
  logic [6:0] state_dbg;

  int n_vec = 0;
  int n_bad = 0;
  bit ended = 0;

  always #4 clk = ~clk;

  // register file model: contents derived from the address
  assign reg_rdata = {reg_addr[2:0], reg_addr} ^ 8'hA5;

  seq_cmd_ctrl i_seq_cmd_ctrl (.*);

  // snapshot taken in an accept cycle
  logic       s_rdy, s_we, s_ld, s_st, s_xs, s_xk, s_ds;
  logic [4:0] s_addr;
  logic [7:0] s_wd, s_xo;

  localparam logic [15:0] VEC [0:10] = '{
    16'h0A3C, 16'h1FFF, 16'h2500, 16'h2000, 16'h4300, 16'h7100,
    16'h8085, 16'hA712, 16'hC000, 16'hE900, 16'h4000
  };

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    n_vec++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic settle();
    @(negedge clk); #1;
  endtask

  task automatic put(input logic [7:0] b);
    @(negedge clk); in_valid = 1'b1; in_byte = b; #1;
    s_rdy = in_ready; s_we = reg_we; s_ld = obj_load; s_st = obj_store;
    s_xs = xf_start; s_xk = xf_skew; s_ds = draw_start;
    s_addr = reg_addr; s_wd = reg_wdata; s_xo = xf_operand;
    @(posedge clk); #1; in_valid = 1'b0; in_byte = '0;
  endtask

  function automatic int strobes();
    return int'(s_we) + int'(s_ld) + int'(s_st) + int'(s_xs) + int'(s_ds);
  endfunction

  task automatic finish_run();
    if (!ended) begin
      ended = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_vec++; n_bad++;
    $display("FAIL watchdog actual=0 expected=1");
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    // R1 reset state
    chk(state_dbg == 7'b0000001, "R1 state in reset", state_dbg, 1);
    chk(in_ready && !reg_we && !obj_load && !obj_store && !xf_start && !draw_start && !out_valid,
        "R1 outputs in reset", {in_ready, out_valid}, 2);
    @(negedge clk); rst_n = 1'b1;
    settle();
    chk(in_ready == 1'b1 && state_dbg == 7'b0000001, "R1 ready after release",
        {in_ready, state_dbg}, 8'h81);

    // idle fetch: no byte offered, nothing moves
    settle();
    chk(state_dbg == 7'b0000001 && !reg_we, "R9 idle fetch", state_dbg, 1);

    foreach (VEC[k]) begin
      logic [7:0] cmd, arg;
      logic [2:0] op;
      logic [4:0] ix;
      cmd = VEC[k][15:8]; arg = VEC[k][7:0];
      op = cmd[7:5]; ix = cmd[4:0];
      put(cmd);
      chk(s_rdy == 1'b1, "R2 command accepted", s_rdy, 1);
      chk(s_ds == (op == 3'd6), "R7 draw_start on accept", s_ds, (op == 3'd6));
      chk(strobes() <= 1, "R10 strobe count", strobes(), 1);
      case (op)
        3'd0: begin
          settle();
          chk(state_dbg == 7'b0000010, "R9 data wait state", state_dbg, 7'b0000010);
          put(arg);
          chk(s_we && s_addr == ix && s_wd == arg, "R3 register write",
              {s_we, s_addr, s_wd}, {1'b1, ix, arg});
          settle();
          chk(in_ready && state_dbg == 7'b0000001, "R3 back to fetch", state_dbg, 1);
        end
        3'd1: begin
          settle();
          chk(out_valid && !in_ready && out_byte == ({ix[2:0], ix} ^ 8'hA5),
              "R4 read-out", {out_valid, in_ready, out_byte}, {2'b10, {ix[2:0], ix} ^ 8'hA5});
          chk(state_dbg == 7'b0000100, "R9 read-out state", state_dbg, 7'b0000100);
          settle();
          chk(out_valid && out_byte == ({ix[2:0], ix} ^ 8'hA5), "R4 hold",
              out_byte, {ix[2:0], ix} ^ 8'hA5);
          out_ready = 1'b1;
          @(posedge clk); #1; out_ready = 1'b0;
          settle();
          chk(!out_valid && out_byte == 8'h00 && in_ready, "R4 release",
              {out_valid, out_byte}, 0);
        end
        3'd2, 3'd3: begin
          settle();
          chk(obj_load == (op == 3'd2) && obj_store == (op == 3'd3) && obj_idx == ix,
              "R5 object pulse", {obj_load, obj_store, obj_idx},
              {op == 3'd2, op == 3'd3, ix});
          chk(state_dbg == 7'b0001000, "R9 object state", state_dbg, 7'b0001000);
          settle();
          chk(!obj_load && !obj_store && in_ready, "R5 single cycle",
              {obj_load, obj_store}, 0);
        end
        3'd4, 3'd5: begin
          settle();
          chk(state_dbg == 7'b0010000 && in_ready, "R9 operand state", state_dbg, 7'b0010000);
          put(arg);
          chk(s_xs && s_xo == arg && s_xk == (op == 3'd5), "R6 transform start",
              {s_xs, s_xk, s_xo}, {1'b1, op == 3'd5, arg});
          settle();
          chk(!in_ready && state_dbg == 7'b0100000, "R6 wait closed", state_dbg, 7'b0100000);
          settle();
          chk(!in_ready, "R6 still waiting", in_ready, 0);
          xf_done = 1'b1;
          @(posedge clk); #1; xf_done = 1'b0;
          settle();
          chk(in_ready && state_dbg == 7'b0000001, "R6 ready after done", state_dbg, 1);
        end
        3'd6: begin
          settle();
          chk(!in_ready && state_dbg == 7'b1000000, "R7 draw wait", state_dbg, 7'b1000000);
          in_valid = 1'b1; in_byte = 8'h0A;
          for (int j = 0; j < 3; j++) begin
            settle();
            chk(!reg_we && !xf_start && !draw_start && state_dbg == 7'b1000000,
                "R7 bytes ignored", {reg_we, state_dbg}, 7'b1000000);
          end
          in_valid = 1'b0; in_byte = '0;
          draw_done = 1'b1;
          @(posedge clk); #1; draw_done = 1'b0;
          settle();
          chk(in_ready && state_dbg == 7'b0000001, "R7 control returned", state_dbg, 1);
        end
        default: begin
          chk(strobes() == 0, "R8 no strobe", strobes(), 0);
          settle();
          chk(in_ready && state_dbg == 7'b0000001 && !obj_load && !obj_store,
              "R8 stays in fetch", state_dbg, 1);
        end
      endcase
    end

    // reset in the middle of a command: back to fetch
    put(8'h80);
    @(negedge clk); rst_n = 1'b0;
    @(posedge clk); #1;
    chk(state_dbg == 7'b0000001 && in_ready, "R1 reset mid-command", state_dbg, 1);
    @(negedge clk); rst_n = 1'b1;
    // the byte after reset is treated as a command, not an operand
    put(8'h2C);
    chk(!s_xs, "R1 operand dropped by reset", s_xs, 0);
    settle();
    chk(out_valid && out_byte == ({3'b100, 5'h0C} ^ 8'hA5), "R4 read-out after reset",
        out_byte, {3'b100, 5'h0C} ^ 8'hA5);
    out_ready = 1'b1;
    @(posedge clk); #1; out_ready = 1'b0;

    // back-to-back write: data byte and next command without gap
    put(8'h03); put(8'h77); put(8'hE0);
    chk(strobes() == 0, "R8 after write", strobes(), 0);
    settle();
    chk(state_dbg == 7'b0000001, "R3 back-to-back", state_dbg, 1);

    finish_run();
  end

endmodule